// File: doc/BRIEF.md
# Multichannel DAC Serial Register Slave

This block is the digital control port of a multichannel digital-to-analog converter. It runs in its own system clock domain. It oversamples an SPI bus (mode 0: data is sampled on the rising serial-clock edge and changed on the falling edge) and collects 24-bit command frames. It decodes each frame into a 2-bit command, a 6-bit address and a 16-bit payload. From these it updates a per-channel register file of input data, offset trim and gain trim, plus a small set of special-function registers: a control word with a power-down flag, and one offset register for each channel group.

To read a register, the host spends two frames. The first frame is a special-function readback request that names a register type and an address. During the second frame the slave shifts the requested 16-bit value out on MISO. Every other frame shifts out zeros.

The serial pins carry a fixed framing with no flow control, so there is no valid/ready handshake. SCLK, CS_N and MOSI are synchronised inside the block. The serial clock must stay at or below one eighth of the system clock rate.

Top module: `dac_spi_slave`

## Requirements
- R1: A frame is 24 bits, sent MSB first. Bits [23:22] are the command, bits [21:16] the address and bits [15:0] the payload.
- R2: A frame takes effect only when exactly 24 rising SCLK edges occur while CS_N is low. A frame with 23 or 25 edges changes no register.
- R3: Command 0 to address 1 stores payload bit 0 as the power-down flag. The flag drives `power_down` and reads back as bit 0 of readback type 4, address 1.
- R4: Channel n sits at address 8+n for n < NUM_CH. Command 3 writes its input data, command 2 its offset trim and command 1 its gain trim. When DATA_BITS < 16, the payload is kept left-justified and its low 16-DATA_BITS bits are cleared.
- R5: Command 0 to address 5 is a readback request. Payload bits [15:13] are the type (0 data, 2 offset trim, 3 gain trim, 4 special function) and bits [12:7] are the address. During the next frame MISO returns 8 zero bits followed by the 16-bit value, MSB first.
- R6: The value is returned only during the frame right after the request. A later frame that is not preceded by a request shifts out all zeros.
- R7: The following are ignored and return zero: writes to unmapped addresses, the no-op at address 0, readback type 1, readback types 5 to 7, and readbacks of unmapped addresses.
- R8: Command 0 to address 2+g, for g < NUM_GRP (NUM_GRP ≤ 3), writes the 14-bit offset of group g from payload bits [13:0]. Group addresses at or above 2+NUM_GRP are ignored.
- R9: After reset, every register reads zero except gain trim, which reads all ones within the DATA_BITS mask. `power_down` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial readback data out |
| power_down | output | 1 | Stored global power-down flag |

## Verification
The bench sends frames one bit short and one bit long. A slave that committed on any CS_N rise would corrupt a channel it had already written. It checks that a readback answer appears in exactly one frame; a design that kept its staging register loaded would echo the old value into the following frame. Writes to the channel just past the last one, to an unconfigured group offset address, and the reserved readback types all probe decode edges; a loose compare there would alias onto channel 0 or group 0 and return nonzero data. The reset value of gain trim is checked as all ones, not zero.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;
  localparam int FRAME_W = 24;
  localparam int OFS_W   = 14;

  localparam logic [5:0] SF_CTRL = 6'd1;
  localparam logic [5:0] SF_OFS0 = 6'd2;
  localparam logic [5:0] SF_RDBK = 6'd5;
  localparam logic [5:0] CH_BASE = 6'd8;

  typedef enum logic [1:0] {
    CMD_SF   = 2'd0,
    CMD_GAIN = 2'd1,
    CMD_OFS  = 2'd2,
    CMD_DATA = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    RB_DATA   = 3'd0,
    RB_DATA_B = 3'd1,
    RB_OFS    = 3'd2,
    RB_GAIN   = 3'd3,
    RB_SF     = 3'd4
  } rb_e;

  typedef struct packed {
    cmd_e        cmd;
    logic [5:0]  addr;
    logic [15:0] payload;
  } frame_t;
endpackage

// File: rtl/spi_frame_port.sv
module spi_frame_port
  import dacspi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        frm_vld_o,
  output frame_t      frm_o,
  input  logic        rb_hit_i,
  input  logic [15:0] rb_data_i
);
  localparam int CW      = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic [2:0]         meta_q, sync_q;
  logic               sclk_s, cs_s, mosi_s;
  logic               sclk_d, cs_d;
  logic [CW-1:0]      cnt_q;
  logic [FRAME_W-1:0] sh_q, tx_q;

  assign {sclk_s, cs_s, mosi_s} = sync_q;

  wire sclk_rise = sclk_s & ~sclk_d;
  wire sclk_fall = ~sclk_s & sclk_d;
  wire cs_fall   = ~cs_s & cs_d;
  wire cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 3'b010;
      sync_q <= 3'b010;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      meta_q <= {sclk, cs_n, mosi};
      sync_q <= meta_q;
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  // receive shifter with saturating edge count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!cs_s && sclk_rise) begin
      sh_q <= {sh_q[FRAME_W-2:0], mosi_s};
      if (cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign frm_vld_o = cs_rise && (cnt_q == CW'(FRAME_W));
  assign frm_o     = frame_t'(sh_q);

  // transmit staging: loaded at every frame end, shifted on falling SCLK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
    end else if (cs_rise) begin
      tx_q <= rb_hit_i ? {{(FRAME_W-16){1'b0}}, rb_data_i} : '0;
    end else if (!cs_s && sclk_fall) begin
      tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso = tx_q[FRAME_W-1];

  AST_TX_HI_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |-> (tx_q[FRAME_W-1:16] == '0)); // R5
  AST_TX_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_d) |=> $stable(tx_q)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CNT_MAX)); // R2
endmodule

// File: rtl/dac_regs.sv
module dac_regs
  import dacspi_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_GRP   = 2,
  parameter int DATA_BITS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_vld_i,
  input  frame_t      frm_i,
  output logic        rb_hit_o,
  output logic [15:0] rb_data_o,
  output logic        power_down_o
);
  localparam logic [15:0] DMASK = 16'hFFFF << (16 - DATA_BITS);

  logic [15:0]      data_q [NUM_CH];
  logic [15:0]      ofs_q  [NUM_CH];
  logic [15:0]      gain_q [NUM_CH];
  logic [OFS_W-1:0] grp_q  [NUM_GRP];
  logic             pd_q;

  wire       sf_wr   = frm_vld_i && (frm_i.cmd == CMD_SF);
  wire [2:0] rb_type = frm_i.payload[15:13];
  wire [5:0] rb_addr = frm_i.payload[12:7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        data_q[c] <= '0;
        ofs_q[c]  <= '0;
        gain_q[c] <= DMASK;
      end
      for (int g = 0; g < NUM_GRP; g++) grp_q[g] <= '0;
      pd_q <= 1'b0;
    end else if (frm_vld_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (frm_i.addr == 6'(CH_BASE + c)) begin
          case (frm_i.cmd)
            CMD_DATA: data_q[c] <= frm_i.payload & DMASK;
            CMD_OFS:  ofs_q[c]  <= frm_i.payload & DMASK;
            CMD_GAIN: gain_q[c] <= frm_i.payload & DMASK;
            default:  ;
          endcase
        end
      end
      if (sf_wr) begin
        for (int g = 0; g < NUM_GRP; g++)
          if (frm_i.addr == 6'(SF_OFS0 + g)) grp_q[g] <= frm_i.payload[OFS_W-1:0];
        if (frm_i.addr == SF_CTRL) pd_q <= frm_i.payload[0];
      end
    end
  end

  assign rb_hit_o     = sf_wr && (frm_i.addr == SF_RDBK);
  assign power_down_o = pd_q;

  always_comb begin
    rb_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rb_addr == 6'(CH_BASE + c)) begin
        case (rb_type)
          RB_DATA: rb_data_o = data_q[c];
          RB_OFS:  rb_data_o = ofs_q[c];
          RB_GAIN: rb_data_o = gain_q[c];
          default: ;
        endcase
      end
    end
    if (rb_type == RB_SF) begin
      if (rb_addr == SF_CTRL) rb_data_o = {15'd0, pd_q};
      for (int g = 0; g < NUM_GRP; g++)
        if (rb_addr == 6'(SF_OFS0 + g)) rb_data_o = {{(16-OFS_W){1'b0}}, grp_q[g]};
    end
  end

  AST_PD_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> $past(frm_vld_i)); // R3
  AST_CH0_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(data_q[0]) || !$stable(gain_q[0])) |-> $past(frm_vld_i)); // R7
endmodule

// File: rtl/dac_spi_slave.sv
module dac_spi_slave
  import dacspi_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int NUM_GRP   = 2,
  parameter int DATA_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic power_down
);
  logic        frm_vld;
  frame_t      frm;
  logic        rb_hit;
  logic [15:0] rb_data;

  spi_frame_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .frm_vld_o (frm_vld),
    .frm_o     (frm),
    .rb_hit_i  (rb_hit),
    .rb_data_i (rb_data)
  );

  dac_regs #(
    .NUM_CH    (NUM_CH),
    .NUM_GRP   (NUM_GRP),
    .DATA_BITS (DATA_BITS)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_vld_i    (frm_vld),
    .frm_i        (frm),
    .rb_hit_o     (rb_hit),
    .rb_data_o    (rb_data),
    .power_down_o (power_down)
  );
endmodule

// File: tb/test_dac_spi_slave.sv
module test_dac_spi_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, power_down;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  dac_spi_slave i_dac_spi_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .power_down(power_down)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input int nbits, input logic [31:0] word, output logic [31:0] got);
    got = '0;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[nbits-1-i];
      wait_clk(8);
      sclk = 1'b1;
      got  = {got[30:0], miso};
      wait_clk(8);
      sclk = 1'b0;
    end
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic wr(input logic [1:0] cmd, input logic [5:0] addr, input logic [15:0] d);
    logic [31:0] g;
    xfer(24, {8'd0, cmd, addr, d}, g);
  endtask

  task automatic rd(input logic [2:0] typ, input logic [5:0] addr, output logic [31:0] v);
    logic [31:0] g;
    xfer(24, {8'd0, 2'd0, 6'd5, typ, addr, 7'd0}, g);
    xfer(24, 32'd0, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R9 power_down", {31'd0, power_down}, 32'd0);
    check("R9 miso idle", {31'd0, miso}, 32'd0);
    rd(3'd3, 6'd8, v);  check("R9 gain ch0", v, 32'h0000FFFF);
    rd(3'd0, 6'd23, v); check("R9 data ch15", v, 32'd0);
    rd(3'd2, 6'd9, v);  check("R9 offset ch1", v, 32'd0);
  endtask

  task automatic t_channel;
    logic [31:0] v;
    wr(2'd3, 6'd8, 16'hA5C3);
    wr(2'd3, 6'd23, 16'h8001);
    wr(2'd2, 6'd12, 16'h1234);
    wr(2'd1, 6'd12, 16'h7E00);
    rd(3'd0, 6'd8, v);  check("R4 R1 data ch0", v, 32'h0000A5C3);
    rd(3'd0, 6'd23, v); check("R4 data ch15", v, 32'h00008001);
    rd(3'd2, 6'd12, v); check("R4 offset ch4", v, 32'h00001234);
    rd(3'd3, 6'd12, v); check("R5 gain ch4", v, 32'h00007E00);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(2'd0, 6'd1, 16'hFFFF);
    check("R3 power_down set", {31'd0, power_down}, 32'd1);
    rd(3'd4, 6'd1, v); check("R3 ctrl readback", v, 32'd1);
    wr(2'd0, 6'd1, 16'hFFFE);
    check("R3 power_down clear", {31'd0, power_down}, 32'd0);
  endtask

  task automatic t_group;
    logic [31:0] v;
    wr(2'd0, 6'd2, 16'h3FFF);
    wr(2'd0, 6'd3, 16'hABCD);
    wr(2'd0, 6'd4, 16'h1111);
    rd(3'd4, 6'd2, v); check("R8 group0", v, 32'h00003FFF);
    rd(3'd4, 6'd3, v); check("R8 group1 14 bits", v, 32'h00002BCD);
    rd(3'd4, 6'd4, v); check("R8 group2 absent", v, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(2'd3, 6'd7, 16'hBEEF);
    wr(2'd3, 6'd24, 16'hBEEF);
    wr(2'd0, 6'd0, 16'hFFFF);
    rd(3'd0, 6'd8, v);  check("R7 ch0 untouched", v, 32'h0000A5C3);
    rd(3'd0, 6'd24, v); check("R7 past last channel", v, 32'd0);
    rd(3'd1, 6'd8, v);  check("R7 type1 zero", v, 32'd0);
    rd(3'd5, 6'd8, v);  check("R7 type5 zero", v, 32'd0);
    rd(3'd4, 6'd0, v);  check("R7 nop reads zero", v, 32'd0);
    check("R7 nop no power_down", {31'd0, power_down}, 32'd0);
  endtask

  task automatic t_length;
    logic [31:0] g, v;
    wr(2'd3, 6'd9, 16'h1234);
    xfer(23, {9'd0, 1'b1, 6'd9, 16'hFFFF}, g);
    rd(3'd0, 6'd9, v); check("R2 short frame", v, 32'h00001234);
    xfer(25, {7'd0, 1'b0, 2'd3, 6'd9, 16'hFFFF}, g);
    rd(3'd0, 6'd9, v); check("R2 long frame", v, 32'h00001234);
  endtask

  task automatic t_once;
    logic [31:0] v, g;
    rd(3'd0, 6'd8, v); check("R5 answer", v, 32'h0000A5C3);
    xfer(24, 32'd0, g); check("R6 next frame zero", g, 32'd0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_channel();
    t_ctrl();
    t_group();
    t_unmapped();
    t_length();
    t_once();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule